// File: doc/BRIEF.md
# Serial Memory Slave Interface

This block is the two-wire bus front end of a 4096-byte memory. It samples SCL and SDA with the system clock and recognises bus Start and Stop conditions. It decodes the control byte against a fixed device code and three strap inputs, and acknowledges each byte it accepts. For a write, it collects a 12-bit word address and the data bytes that follow. For a read, it shifts bytes out of a simple memory port. SDA is driven only as an active-high pull-low enable, which suits an open-drain pad.

Accepted data bytes leave as single-cycle write requests to a separate write-commit block, which handles page buffering and the programming cycle itself. That block reports an active programming cycle on `prog_busy`. While it is high, the interface acknowledges nothing.

A random read is done with a dummy write that carries only the address, then a repeated Start and a read control byte. A read that starts straight after a Start continues from the current pointer.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high is a Start. From any state, including the middle of a byte, it clears the bit position and begins a new control byte.
- R2: A rising SDA while SCL is high is a Stop. It returns the block to idle with SDA released. Bus activity is then ignored until the next Start: no acknowledge and no write request.
- R3: The control byte arrives MSB first. Bits [7:4] must be 4'b1010 and bits [3:1] must equal strap_sel[2:0]; bit 0 = 0 selects write and bit 0 = 1 selects read. On any mismatch the byte is not acknowledged and the rest of the transfer is ignored.
- R4: After each accepted byte, sda_pull is 1 throughout the ninth SCL pulse. It is 0 during the eight data pulses of every received byte.
- R5: If prog_busy is high when the eighth bit of a received byte completes, that byte gets no acknowledge and no write request, and the transfer is dropped.
- R6: After a write control byte, the first address byte supplies pointer bits [11:8] from its bits [3:0], and its bits [7:4] are ignored. The second address byte supplies pointer bits [7:0].
- R7: Each later accepted byte produces a one-cycle wr_req carrying wr_addr = pointer and wr_data = the byte. The pointer then increments.
- R8: In a read, the byte at rd_addr is shifted out MSB first, with sda_pull = inverse of the bit, one bit per SCL pulse. The pointer increments after each byte and wraps from 12'hFFF to 12'h000.
- R9: If the master does not acknowledge a read byte, SDA stays released and the block drives nothing until the next Start.
- R10: sda_pull changes only while SCL is low, three clock edges after the SCL falling edge at the pin (two synchroniser flops plus the edge register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| strap_sel | input | 3 | Device-select straps compared with control bits [3:1] |
| prog_busy | input | 1 | Programming cycle in progress; suppresses acknowledges |
| rd_addr | output | ADDR_W | Read address for the memory port (current pointer) |
| rd_data | input | 8 | Byte stored at rd_addr, valid within one clock |
| wr_req | output | 1 | One-cycle write request |
| wr_addr | output | ADDR_W | Address of the write request |
| wr_data | output | 8 | Data of the write request |

## Verification
sda_pull responds to an SCL falling edge at the pin three clock edges later, so every slave-driven bit settles early in a low phase that lasts sixteen cycles. The reference model states the expected pull for each SCL pulse. The bench compares it on every clock from the fourth cycle after the rising edge until just before the fall, which keeps the synchroniser delay out of the comparison. A write request appears three edges after the falling edge that ends the eighth data bit. The bench queues each request as it occurs and matches the queue against the model's list once the transfer ends, so no fixed cycle count is assumed.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int DATA_W  = 8;
    localparam int STRAP_W = 3;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic ctrl_match(input logic [DATA_W-1:0] b,
                                        input logic [STRAP_W-1:0] strap);
        return (b[7:4] == DEV_CODE) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/smem_bus_cond.sv
module smem_bus_cond
    import smem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_sr;
    logic [LAST:0] sda_sr;
    logic          scl_q;
    logic          sda_q;

    // per-stage flops; idle bus level is high
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_sr[g] <= 1'b1;
                sda_sr[g] <= 1'b1;
            end else if (g == 0) begin
                scl_sr[g] <= scl_in;
                sda_sr[g] <= sda_in;
            end else begin
                scl_sr[g] <= scl_sr[(g == 0) ? 0 : g-1];
                sda_sr[g] <= sda_sr[(g == 0) ? 0 : g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sr[LAST];
            sda_q <= sda_sr[LAST];
        end
    end

    logic scl_s, sda_s;
    assign scl_s = scl_sr[LAST];
    assign sda_s = sda_sr[LAST];

    always_comb begin
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/smem_addr_ptr.sv
module smem_addr_ptr
    import smem_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              inc,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] ptr
);

    localparam int HI_W = ADDR_W - DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ld_hi) begin
            ptr[ADDR_W-1:DATA_W] <= din[HI_W-1:0];
        end else if (ld_lo) begin
            ptr[DATA_W-1:0] <= din;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
    import smem_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic               prog_busy,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [ADDR_W-1:0]  ptr,
    output logic               ptr_ld_hi,
    output logic               ptr_ld_lo,
    output logic               ptr_inc,
    output logic [DATA_W-1:0]  ld_byte,
    output logic               sda_pull,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               tx_mode,
    output logic               idle
);

    localparam int          CNT_W   = 4;
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W + 1);

    phase_t              phase;
    logic [CNT_W-1:0]    bitcnt;
    logic [DATA_W-1:0]   rx;
    logic [DATA_W-2:0]   tx;
    logic                rw;
    logic                mack;

    logic receiving;
    logic ack_fall;
    logic end_ack;
    logic byte_ok;

    always_comb begin
        receiving = (phase == PH_CTRL) || (phase == PH_AHI) ||
                    (phase == PH_ALO)  || (phase == PH_WDAT);
        ack_fall  = receiving && ev.fall && (bitcnt == BIT_LAST);
        end_ack   = ev.fall && (bitcnt == ACK_SLOT);
        byte_ok   = !prog_busy && ((phase != PH_CTRL) || ctrl_match(rx, strap));
        ptr_ld_hi = ack_fall && byte_ok && (phase == PH_AHI);
        ptr_ld_lo = ack_fall && byte_ok && (phase == PH_ALO);
        ptr_inc   = (ack_fall && byte_ok && (phase == PH_WDAT)) ||
                    ((phase == PH_RDAT) && ev.fall && (bitcnt == BIT_LAST));
        ld_byte   = rx;
        tx_mode   = (phase == PH_RDAT);
        idle      = (phase == PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            wr_req   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_req <= 1'b0;
            if (ev.start) begin
                phase    <= PH_CTRL;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (phase)
                    PH_CTRL, PH_AHI, PH_ALO, PH_WDAT: begin
                        if (ev.rise && (bitcnt < BIT_LAST)) begin
                            rx     <= {rx[DATA_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ack_fall) begin
                            if (byte_ok) begin
                                sda_pull <= 1'b1;
                                bitcnt   <= ACK_SLOT;
                                if (phase == PH_CTRL) rw <= rx[0];
                                if (phase == PH_WDAT) begin
                                    wr_req  <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= rx;
                                end
                            end else begin
                                phase    <= PH_IDLE;
                                bitcnt   <= '0;
                                sda_pull <= 1'b0;
                            end
                        end else if (end_ack) begin
                            bitcnt   <= '0;
                            sda_pull <= 1'b0;
                            case (phase)
                                PH_CTRL: begin
                                    if (rw) begin
                                        phase    <= PH_RDAT;
                                        tx       <= rd_data[DATA_W-2:0];
                                        sda_pull <= ~rd_data[DATA_W-1];
                                    end else begin
                                        phase <= PH_AHI;
                                    end
                                end
                                PH_AHI:  phase <= PH_ALO;
                                PH_ALO:  phase <= PH_WDAT;
                                default: phase <= PH_WDAT;
                            endcase
                        end
                    end
                    PH_RDAT: begin
                        if (ev.rise) begin
                            if (bitcnt < BIT_LAST)
                                bitcnt <= bitcnt + 1'b1;
                            else if (bitcnt == ACK_SLOT)
                                mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if ((bitcnt != '0) && (bitcnt < BIT_LAST)) begin
                                sda_pull <= ~tx[DATA_W-2];
                                tx       <= {tx[DATA_W-3:0], 1'b0};
                            end else if (bitcnt == BIT_LAST) begin
                                sda_pull <= 1'b0;
                                bitcnt   <= ACK_SLOT;
                            end else if (bitcnt == ACK_SLOT) begin
                                bitcnt <= '0;
                                if (mack) begin
                                    tx       <= rd_data[DATA_W-2:0];
                                    sda_pull <= ~rd_data[DATA_W-1];
                                end else begin
                                    phase    <= PH_IDLE;
                                    sda_pull <= 1'b0;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import smem_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [2:0]        strap_sel,
    input  logic              prog_busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    bus_ev_t             ev;
    logic                ptr_ld_hi;
    logic                ptr_ld_lo;
    logic                ptr_inc;
    logic [DATA_W-1:0]   ld_byte;
    logic [ADDR_W-1:0]   ptr;
    logic                tx_mode;
    logic                idle;

    smem_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    smem_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .ld_hi (ptr_ld_hi),
        .ld_lo (ptr_ld_lo),
        .inc   (ptr_inc),
        .din   (ld_byte),
        .ptr   (ptr)
    );

    smem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (strap_sel),
        .prog_busy (prog_busy),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .ptr_ld_hi (ptr_ld_hi),
        .ptr_ld_lo (ptr_ld_lo),
        .ptr_inc   (ptr_inc),
        .ld_byte   (ld_byte),
        .sda_pull  (sda_pull),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tx_mode   (tx_mode),
        .idle      (idle)
    );

    assign rd_addr = ptr;

endmodule

// File: rtl/serial_mem_slave_chk.sv
module serial_mem_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_pull,
    input logic prog_busy,
    input logic wr_req,
    input logic tx_mode,
    input logic idle
);

    // R10: the pull enable moves only after SCL has been low at the pin
    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !$past(scl_in, 3));

    // R9 / R2: an idle block never holds SDA low
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
        idle |-> !sda_pull);

    // R7: write requests are single-cycle pulses
    assert_wr_single_R7: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !wr_req);

    // R5: no write request from a byte decided while busy
    assert_wr_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !$past(prog_busy));

    // R5: no acknowledge pull starts while busy outside of read transmission
    assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_pull) && !tx_mode) |-> !$past(prog_busy));

endmodule

bind serial_mem_slave serial_mem_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .prog_busy (prog_busy),
    .wr_req    (wr_req),
    .tx_mode   (tx_mode),
    .idle      (idle)
);

// File: tb/serial_mem_slave_test.sv
`timescale 1ns/1ps
module serial_mem_slave_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        scl  = 1'b1;
    logic        msda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        busy = 1'b0;
    logic        sda_pull;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_req;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;

    wire sda_bus = msda & ~sda_pull;

    function automatic logic [7:0] mem_at(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    assign rd_data = mem_at(rd_addr);

    serial_mem_slave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl),
        .sda_in    (sda_bus),
        .sda_pull  (sda_pull),
        .strap_sel (strap),
        .prog_busy (busy),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 1'b0;
    logic  chk_en = 1'b0;
    logic  exp_pull = 1'b0;
    string exp_tag = "";

    // behavioural model state
    int          m_phase = 0;   // 0 idle, 1 control, 2 addr hi, 3 addr lo, 4 write data, 5 read
    logic [11:0] m_ptr = 12'h000;
    logic [19:0] exp_wr[$];
    logic [19:0] got_wr[$];

    always @(negedge clk) begin
        if (chk_en) begin
            nchk++;
            if (sda_pull !== exp_pull) begin
                nerr++;
                $display("FAIL %s: sda_pull=%0b expected %0b at %0t", exp_tag, sda_pull, exp_pull, $time);
            end
        end
        if (!rst && wr_req === 1'b1) got_wr.push_back({wr_addr, wr_data});
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic mbit, input logic ep, input string tag, output logic seen);
        if (scl) begin ticks(8); scl = 1'b0; end
        ticks(8); msda = mbit;
        ticks(8); scl = 1'b1;
        ticks(4); exp_pull = ep; exp_tag = tag; chk_en = 1'b1;
        ticks(4); seen = sda_bus;
        ticks(7); chk_en = 1'b0;
        ticks(1); scl = 1'b0;
    endtask

    task automatic bus_start();
        if (!scl) begin ticks(8); msda = 1'b1; ticks(8); scl = 1'b1; end
        ticks(8); msda = 1'b0;
        ticks(8); scl = 1'b0;
        m_phase = 1;
    endtask

    task automatic bus_stop(input string tag);
        if (scl) begin ticks(8); scl = 1'b0; end
        ticks(8); msda = 1'b0;
        ticks(8); scl = 1'b1;
        ticks(8); msda = 1'b1;
        ticks(8);
        m_phase = 0;
        check_eq(tag, sda_pull, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        logic ack;
        logic seen;
        ack = 1'b0;
        case (m_phase)
            1: begin
                ack = (b[7:4] == 4'b1010) && (b[3:1] == strap) && !busy;
                m_phase = ack ? (b[0] ? 5 : 2) : 0;
            end
            2: begin
                ack = !busy;
                if (ack) begin m_ptr[11:8] = b[3:0]; m_phase = 3; end else m_phase = 0;
            end
            3: begin
                ack = !busy;
                if (ack) begin m_ptr[7:0] = b; m_phase = 4; end else m_phase = 0;
            end
            4: begin
                ack = !busy;
                if (ack) begin exp_wr.push_back({m_ptr, b}); m_ptr = m_ptr + 12'd1; end
                else m_phase = 0;
            end
            default: ack = 1'b0;
        endcase
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, tag, seen);
        clk_bit(1'b1, ack, tag, seen);
    endtask

    task automatic recv_byte(input logic mack, input string tag);
        logic [7:0] e;
        logic [7:0] got;
        logic       active;
        logic       seen;
        active = (m_phase == 5);
        e = mem_at(m_ptr);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, active ? ~e[i] : 1'b0, tag, seen);
            got[i] = seen;
        end
        clk_bit(~mack, 1'b0, tag, seen);
        if (active) begin
            check_eq(tag, got, e);
            m_ptr = m_ptr + 12'd1;
            if (!mack) m_phase = 0;
        end
    endtask

    task automatic check_writes(input string tag);
        check_eq({tag, " count"}, got_wr.size(), exp_wr.size());
        for (int i = 0; i < exp_wr.size() && i < got_wr.size(); i++)
            check_eq(tag, got_wr[i], exp_wr[i]);
        got_wr.delete();
        exp_wr.delete();
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R1 watchdog: run not finished, got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic seen;
        ticks(10);
        rst = 1'b0;
        ticks(5);
        check_eq("R4 reset pull", sda_pull, 0);
        check_eq("R7 reset wr_req", wr_req, 0);

        // R3 R4 R6 R7: write three bytes, upper nibble of hi address ignored
        bus_start();
        send_byte(8'hAA, "R3 write control");
        send_byte(8'hF3, "R6 addr hi");
        send_byte(8'hFE, "R6 addr lo");
        send_byte(8'h11, "R7 data0");
        send_byte(8'h22, "R7 data1");
        send_byte(8'h33, "R7 data2");
        bus_stop("R2 stop after write");
        check_writes("R7 write requests");

        // R1 R8 R9: random read across the wrap point
        bus_start();
        send_byte(8'hAA, "R3 dummy write");
        send_byte(8'h0F, "R6 addr hi");
        send_byte(8'hFE, "R6 addr lo");
        bus_start();
        send_byte(8'hAB, "R1 read control after restart");
        recv_byte(1'b1, "R8 read FFE");
        recv_byte(1'b1, "R8 read FFF");
        recv_byte(1'b0, "R8 read wrap 000");
        recv_byte(1'b1, "R9 released after nack");
        bus_stop("R9 stop after nack");
        check_writes("R7 none in read");

        // R8: current address read
        bus_start();
        send_byte(8'hAB, "R3 read control");
        recv_byte(1'b0, "R8 current read");
        bus_stop("R2 stop");

        // R3: strap mismatch and device code mismatch
        bus_start();
        send_byte(8'hA4, "R3 strap mismatch");
        send_byte(8'h00, "R3 ignored byte");
        send_byte(8'h55, "R3 ignored byte");
        bus_stop("R2 stop");
        bus_start();
        send_byte(8'hBA, "R3 code mismatch");
        send_byte(8'h01, "R3 ignored byte");
        bus_stop("R2 stop");
        check_writes("R3 no writes");

        // R5: busy on control byte and busy mid-write
        busy = 1'b1;
        bus_start();
        send_byte(8'hAA, "R5 busy control");
        send_byte(8'h00, "R5 dropped byte");
        bus_stop("R2 stop");
        busy = 1'b0;
        bus_start();
        send_byte(8'hAA, "R5 control ok");
        busy = 1'b1;
        send_byte(8'h01, "R5 busy addr");
        busy = 1'b0;
        send_byte(8'h02, "R5 dropped after busy");
        bus_stop("R2 stop");
        check_writes("R5 no writes");

        // R1: restart in the middle of a byte
        bus_start();
        clk_bit(1'b1, 1'b0, "R1 partial", seen);
        clk_bit(1'b0, 1'b0, "R1 partial", seen);
        clk_bit(1'b1, 1'b0, "R1 partial", seen);
        bus_start();
        send_byte(8'hAA, "R1 control after mid restart");
        send_byte(8'h02, "R6 addr hi");
        send_byte(8'h10, "R6 addr lo");
        send_byte(8'h77, "R7 data");
        bus_stop("R2 stop");
        check_writes("R1 write after restart");

        // R2: stop mid-byte, then activity without start is ignored
        bus_start();
        send_byte(8'hAA, "R3 control");
        clk_bit(1'b1, 1'b0, "R2 partial", seen);
        clk_bit(1'b0, 1'b0, "R2 partial", seen);
        clk_bit(1'b1, 1'b0, "R2 partial", seen);
        clk_bit(1'b0, 1'b0, "R2 partial", seen);
        bus_stop("R2 mid-byte stop");
        send_byte(8'hAA, "R2 ignored control");
        send_byte(8'h00, "R2 ignored byte");
        bus_stop("R2 stop");
        check_writes("R2 no writes");

        // R8: pointer continues after writes
        bus_start();
        send_byte(8'hAB, "R3 read control");
        recv_byte(1'b1, "R8 read after write");
        recv_byte(1'b0, "R8 read next");
        bus_stop("R9 stop");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule